// File: doc/BRIEF.md
# Multi-Context Address Region Matcher

This block decides which of several programmable address windows a bus access falls into. Each window, called a context, has a start block and an end block at 1 KB granularity, a valid flag and a decrypt-enable flag. When an address strobe arrives, the block compares the address against all contexts in parallel. One clock later it reports either a single hit context or a region error.

A region error is raised when no window matches, and also when more than one window matches. Overlapping windows are never resolved by priority. On a clean hit the block also says whether the downstream datapath should decrypt the access. It does so only when the hit context's decrypt-enable flag and the global enable are both set.

A small state machine holds the verdict. `ST_EMPTY` is the state after reset, before any strobe. `ST_HIT` means the last strobe matched exactly one context. `ST_ERR` means it matched none or several. Every strobe moves the machine to `ST_HIT` if exactly one context matched and to `ST_ERR` otherwise. Without a strobe the state is held, and so are the index and the decrypt flag registered beside it.

Top module: `region_matcher`

## Requirements
- R1: Only address bits [31:10] take part in the comparison. An address with any value in bits [9:0] matches exactly as the same address with those bits cleared.
- R2: A valid context matches when its start block is less than or equal to addr[31:10] and addr[31:10] is less than or equal to its end block. Both bounds are inclusive.
- R3: A context whose valid bit is 0 never matches, whatever its bounds are.
- R4: A context whose start block is greater than its end block never matches, even with its valid bit at 1.
- R5: When no context matches, `region_err` is 1, `hit` is 0, `hit_ctx` is 0 and `decrypt_req` is 0.
- R6: When two or more contexts match, the result is a region error, exactly as in R5. No context is chosen by priority.
- R7: When exactly one context matches, `hit` is 1, `region_err` is 0 and `hit_ctx` holds that context's number. Context k occupies bits [k*22 +: 22] of the bound buses and bit k of the flag buses.
- R8: `decrypt_req` is 1 only on a hit, and only when bit `hit_ctx` of `ctx_decen` and `global_en` were both 1 at the strobe.
- R9: The result appears on the outputs one clock after the cycle in which `addr_vld` is sampled high. It stays unchanged until the next strobe, whatever the address, region and enable inputs do in between.
- R10: After reset, `hit`, `region_err`, `hit_ctx` and `decrypt_req` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_vld | input | 1 | Address strobe |
| addr | input | 32 | Bus address |
| global_en | input | 1 | Global decrypt enable |
| ctx_start | input | 88 | Start blocks, 22 bits per context |
| ctx_end | input | 88 | End blocks, 22 bits per context |
| ctx_valid | input | 4 | Valid flag per context |
| ctx_decen | input | 4 | Decrypt-enable flag per context |
| hit | output | 1 | Exactly one context matched |
| hit_ctx | output | 2 | Number of the matched context |
| decrypt_req | output | 1 | Decrypt the access |
| region_err | output | 1 | No context or several contexts matched |

## Verification
The hardest case to reach is a true overlap. Two valid windows have to share blocks, and the probe address has to land inside the shared part, so that the count reaches two. The stimulus builds this on purpose: it widens a neighbouring window until it covers part of context 0, then probes a block in the shared span. It also programs an inverted window whose valid bit is set, and probes both of its edge blocks. A third sequence changes the address, the windows and the global enable with the strobe low, then checks that the held verdict has not moved.

// File: rtl/region_matcher_pkg.sv
package region_matcher_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_HIT   = 2'd1,
        ST_ERR   = 2'd2
    } match_state_t;

endpackage

// File: rtl/region_cmp.sv
module region_cmp #(
    parameter int BLK_W = 22
) (
    input  logic [BLK_W-1:0] blk_i,
    input  logic [BLK_W-1:0] lo_i,
    input  logic [BLK_W-1:0] hi_i,
    input  logic             valid_i,
    output logic             match_o
);

    logic in_window;
    logic well_formed;

    always_comb begin
        well_formed = (lo_i <= hi_i);
        in_window   = (blk_i >= lo_i) && (blk_i <= hi_i);
        match_o     = valid_i && well_formed && in_window;
    end

    // An inverted window must stay empty (R4)
    always_comb begin
        if (lo_i > hi_i) begin
            assert_inverted_empty_R4: assert (!match_o);
        end
    end

endmodule

// File: rtl/hit_resolve.sv
module hit_resolve #(
    parameter int NUM_CTX = 4,
    localparam int IDX_W = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1,
    localparam int CNT_W = $clog2(NUM_CTX + 1)
) (
    input  logic [NUM_CTX-1:0] match_i,
    input  logic [NUM_CTX-1:0] decen_i,
    output logic               single_o,
    output logic [IDX_W-1:0]   idx_o,
    output logic               decen_o
);

    logic [CNT_W-1:0] count;

    always_comb begin
        count   = '0;
        idx_o   = '0;
        decen_o = 1'b0;
        for (int k = 0; k < NUM_CTX; k++) begin
            if (match_i[k]) begin
                count   = count + CNT_W'(1);
                idx_o   = IDX_W'(k);
                decen_o = decen_i[k];
            end
        end
        single_o = (count == CNT_W'(1));
    end

endmodule

// File: rtl/region_matcher.sv
module region_matcher
    import region_matcher_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int GRAN_BITS = 10,
    parameter int NUM_CTX   = 4,
    localparam int BLK_W = ADDR_W - GRAN_BITS,
    localparam int IDX_W = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     addr_vld,
    input  logic [ADDR_W-1:0]        addr,
    input  logic                     global_en,
    input  logic [NUM_CTX*BLK_W-1:0] ctx_start,
    input  logic [NUM_CTX*BLK_W-1:0] ctx_end,
    input  logic [NUM_CTX-1:0]       ctx_valid,
    input  logic [NUM_CTX-1:0]       ctx_decen,
    output logic                     hit,
    output logic [IDX_W-1:0]         hit_ctx,
    output logic                     decrypt_req,
    output logic                     region_err
);

    logic [BLK_W-1:0]     blk;
    logic [GRAN_BITS-1:0] low_bits_unused;
    logic [NUM_CTX-1:0]   match_vec;
    logic                 single;
    logic [IDX_W-1:0]     sel_idx;
    logic                 sel_decen;

    match_state_t         state_q, state_d;
    logic [IDX_W-1:0]     idx_q;
    logic                 dec_q;

    assign blk             = addr[ADDR_W-1:GRAN_BITS];
    assign low_bits_unused = addr[GRAN_BITS-1:0];

    for (genvar g = 0; g < NUM_CTX; g++) begin : g_ctx
        region_cmp #(.BLK_W(BLK_W)) u_cmp (
            .blk_i   (blk),
            .lo_i    (ctx_start[g*BLK_W +: BLK_W]),
            .hi_i    (ctx_end[g*BLK_W +: BLK_W]),
            .valid_i (ctx_valid[g]),
            .match_o (match_vec[g])
        );
    end

    hit_resolve #(.NUM_CTX(NUM_CTX)) u_resolve (
        .match_i  (match_vec),
        .decen_i  (ctx_decen),
        .single_o (single),
        .idx_o    (sel_idx),
        .decen_o  (sel_decen)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY, ST_HIT, ST_ERR: begin
                if (addr_vld) begin
                    state_d = single ? ST_HIT : ST_ERR;
                end
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
            idx_q   <= '0;
            dec_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (addr_vld) begin
                idx_q <= single ? sel_idx : '0;
                dec_q <= single && sel_decen && global_en;
            end
        end
    end

    always_comb begin
        hit         = 1'b0;
        region_err  = 1'b0;
        hit_ctx     = '0;
        decrypt_req = 1'b0;
        unique case (state_q)
            ST_EMPTY: ;
            ST_HIT: begin
                hit         = 1'b1;
                hit_ctx     = idx_q;
                decrypt_req = dec_q;
            end
            ST_ERR:   region_err = 1'b1;
            default: ;
        endcase
    end

    assert_hit_err_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit && region_err));

    assert_err_index_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        region_err |-> (hit_ctx == '0) && !decrypt_req);

    assert_decrypt_needs_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        decrypt_req |-> hit);

    assert_hold_between_strobes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_vld |=> $stable({hit, region_err, hit_ctx, decrypt_req}));

    assert_hit_after_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hit) |-> $past(addr_vld));

endmodule

// File: tb/region_matcher_test.sv
module region_matcher_test;

    localparam int NC = 4;
    localparam int BW = 22;

    typedef struct {
        logic       hit;
        logic       err;
        logic [1:0] ctx;
        logic       dec;
        string      req;
    } exp_t;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               addr_vld = 1'b0;
    logic [31:0]        addr = '0;
    logic               global_en = 1'b0;
    logic [NC*BW-1:0]   ctx_start = '0;
    logic [NC*BW-1:0]   ctx_end = '0;
    logic [NC-1:0]      ctx_valid = '0;
    logic [NC-1:0]      ctx_decen = '0;
    logic               hit;
    logic [1:0]         hit_ctx;
    logic               decrypt_req;
    logic               region_err;

    int   checks = 0;
    int   fails  = 0;
    logic seen   = 1'b0;
    logic done   = 1'b0;
    exp_t sb[$];

    always #2 clk = ~clk;

    region_matcher uut (
        .clk(clk), .rst_n(rst_n), .addr_vld(addr_vld), .addr(addr),
        .global_en(global_en), .ctx_start(ctx_start), .ctx_end(ctx_end),
        .ctx_valid(ctx_valid), .ctx_decen(ctx_decen), .hit(hit),
        .hit_ctx(hit_ctx), .decrypt_req(decrypt_req), .region_err(region_err)
    );

    task automatic compare(exp_t e);
        checks++;
        if (hit !== e.hit || region_err !== e.err || hit_ctx !== e.ctx || decrypt_req !== e.dec) begin
            fails++;
            $display("FAIL %s: got hit=%0b err=%0b ctx=%0d dec=%0b, expected hit=%0b err=%0b ctx=%0d dec=%0b",
                     e.req, hit, region_err, hit_ctx, decrypt_req, e.hit, e.err, e.ctx, e.dec);
        end
    endtask

    task automatic set_ctx(int k, int lo, int hi, logic v, logic de);
        ctx_start[k*BW +: BW] = BW'(lo);
        ctx_end[k*BW +: BW]   = BW'(hi);
        ctx_valid[k]          = v;
        ctx_decen[k]          = de;
    endtask

    function automatic exp_t model(logic [31:0] a, string req);
        exp_t e;
        int   n = 0;
        int   idx = 0;
        logic [BW-1:0] b = a[31:10];
        for (int k = 0; k < NC; k++) begin
            logic [BW-1:0] lo = ctx_start[k*BW +: BW];
            logic [BW-1:0] hi = ctx_end[k*BW +: BW];
            if (ctx_valid[k] && lo <= hi && b >= lo && b <= hi) begin
                n++;
                idx = k;
            end
        end
        e.req = req;
        e.hit = (n == 1);
        e.err = (n != 1);
        e.ctx = (n == 1) ? 2'(idx) : 2'd0;
        e.dec = (n == 1) && ctx_decen[idx] && global_en;
        return e;
    endfunction

    task automatic probe(logic [31:0] a, string req);
        @(negedge clk);
        addr     = a;
        addr_vld = 1'b1;
        sb.push_back(model(a, req));
        @(negedge clk);
        addr_vld = 1'b0;
    endtask

    always @(posedge clk) seen <= addr_vld && rst_n;

    always @(negedge clk) begin
        if (seen && sb.size() > 0) compare(sb.pop_front());
    end

    initial begin
        exp_t last;
        exp_t rst_e;
        rst_e.hit = 0; rst_e.err = 0; rst_e.ctx = 0; rst_e.dec = 0; rst_e.req = "R10";
        repeat (3) @(negedge clk);
        compare(rst_e);
        rst_n = 1'b1;
        @(negedge clk);
        compare(rst_e);

        set_ctx(0, 'h10, 'h1F, 1, 1);
        set_ctx(1, 'h20, 'h2F, 1, 0);
        set_ctx(2, 'h100, 'h100, 1, 0);
        set_ctx(3, 'h0, 'h3FFFFF, 0, 1);
        global_en = 1'b1;

        probe(32'h10 << 10, "R2 lower bound, R7 ctx0, R8 decrypt");
        probe((32'h1F << 10) | 32'h3FF, "R1 low bits ignored, R2 upper bound");
        probe(32'h20 << 10, "R7 ctx1, R8 decen off");
        probe((32'h100 << 10) | 32'h5, "R7 single-block ctx2");
        probe(32'h30 << 10, "R5 no match");
        probe(32'h0F << 10 | 32'h3FF, "R1 R2 just below ctx0");
        probe(32'h500 << 10, "R3 invalid ctx3");

        set_ctx(3, 'h600, 'h5FF, 1, 1);
        probe(32'h600 << 10, "R4 inverted start edge");
        probe(32'h5FF << 10, "R4 inverted end edge");

        set_ctx(1, 'h18, 'h28, 1, 0);
        probe(32'h1A << 10, "R6 overlap ctx0 ctx1");
        probe(32'h28 << 10, "R7 ctx1 outside overlap");
        set_ctx(1, 'h20, 'h2F, 1, 0);

        global_en = 1'b0;
        probe(32'h11 << 10, "R8 global enable off");
        global_en = 1'b1;
        probe(32'h11 << 10, "R8 global enable on");

        @(negedge clk);
        last = model(32'h11 << 10, "R9 hold without strobe");
        addr = 32'h30 << 10;
        set_ctx(0, 'h40, 'h50, 0, 0);
        global_en = 1'b0;
        repeat (3) @(negedge clk);
        compare(last);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(4 * 20000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule